// File: doc/BRIEF.md
# Hypervisor Control Register File

This block holds the control registers a hypervisor-capable core needs for guest status, exception delegation, guest external interrupt enables, counter access and environment configuration, plus two plain storage registers for trap details. Software reaches them through a simple register port: a 12-bit address, a write strobe with write data, and read data that follows the address in the same cycle.

Each register filters what software writes so that only fields the architecture allows to change ever change. The rest read as zero or keep a fixed value. The status register also drives its individual fields out as dedicated wires, so that the trap, privilege and interrupt logic elsewhere in the core can use them without decoding. A read-only pending view shows the guest external interrupt lines supplied by the interrupt controller.

The register width is set by a parameter (32 or 64). A second parameter decides whether the fence-ordering configuration bit can be written. Privilege checks, trap entry and return, and address translation belong to other blocks.

Top module: `hyp_ctrl_regs`

## Requirements
- R1: After reset every register reads zero, except the status register's guest width field (bits 33:32), which reads 2'b10 when XLEN is 64.
- R2: The status register (address 0x600) stores only bits 22, 21, 20, 17:12, 9, 8, 7, 6 and 5 from a write. Every other bit below 32 reads zero.
- R3: With XLEN 64, status bits 33:32 keep their value through every write, and all status bits above 33 read zero.
- R4: With XLEN 32, the status register has no guest width field: the read value is the 32-bit masked value of R2.
- R5: The exception delegation register (0x602) stores every written bit except bits 9, 10, 11, 20, 21, 22 and 23, which always read zero. The stored value is also driven on `exc_deleg_o`.
- R6: The guest external interrupt enable register (0x607) stores all written bits except bit 0, which reads zero.
- R7: The counter enable register (0x606) stores bits 2:0 and reads zero above them. Bits 2:0 also drive `ctr_en_o`.
- R8: The environment configuration register (0x60A) holds only bit 0 (the fence-ordering bit, driven on `fiom_o`). That bit is writable only when FIOM_WRITABLE is 1, and all other bits read zero.
- R9: With XLEN 32, the upper half of the environment configuration register reads at 0x61A. A write to either half leaves the other half unchanged. With XLEN 64, 0x61A reads zero.
- R10: The trap value register (0x643) and the trap instruction register (0x64A) store and return the full written word.
- R11: Address 0xE12 returns `guest_pend_i` and ignores writes. Any unmapped address reads zero and ignores writes.
- R12: `vgein_o` carries status bits 17:12. The single-bit outputs carry status bits 22 (`vtsr_o`), 21 (`vtw_o`), 20 (`vtvm_o`), 9 (`hu_o`), 8 (`spvp_o`), 7 (`spv_o`), 6 (`gva_o`) and 5 (`vsbe_o`).
- R13: A write takes effect at the clock edge that ends its cycle. During the write cycle, the read data still shows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_addr | input | 12 | Register address for read and write |
| csr_we | input | 1 | Write strobe |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data for csr_addr, combinational |
| guest_pend_i | input | XLEN | Guest external interrupt pending lines |
| vgein_o | output | 6 | Selected guest external interrupt number |
| spv_o | output | 1 | Previous virtualization mode flag |
| spvp_o | output | 1 | Previous guest privilege flag |
| vtsr_o | output | 1 | Trap guest supervisor return |
| vtw_o | output | 1 | Trap guest wait-for-interrupt |
| vtvm_o | output | 1 | Trap guest translation management |
| hu_o | output | 1 | Hypervisor instructions allowed in user mode |
| gva_o | output | 1 | Trap value holds a guest virtual address |
| vsbe_o | output | 1 | Guest supervisor big-endian data |
| exc_deleg_o | output | XLEN | Legalized exception delegation mask |
| ctr_en_o | output | 3 | Counter enables (cycle, time, instret) |
| fiom_o | output | 1 | Fence-ordering configuration bit |

## Verification
Reads are combinational, so the read data for an address is due in the cycle the address is presented. Written values appear on the read data and on the exported fields one edge later. The bench drives each access just after a falling edge and compares half a nanosecond later. It updates its reference model only after the rising edge that ends a write cycle. As a result, the comparison during a write cycle confirms the old value (R13), and the comparison in the next cycle confirms the legalized new value. Two instances run side by side, one 64-bit with the fence bit locked and one 32-bit with it writable. Together they cover the guest width field, the split configuration halves and both settings of the fence bit.

// File: rtl/hyp_ctrl_pkg.sv
package hyp_ctrl_pkg;

  // Register addresses
  localparam logic [11:0] A_STATUS  = 12'h600;
  localparam logic [11:0] A_EDELEG  = 12'h602;
  localparam logic [11:0] A_CTREN   = 12'h606;
  localparam logic [11:0] A_GEIE    = 12'h607;
  localparam logic [11:0] A_ENVCFG  = 12'h60A;
  localparam logic [11:0] A_ENVCFGH = 12'h61A;
  localparam logic [11:0] A_TVAL    = 12'h643;
  localparam logic [11:0] A_TINST   = 12'h64A;
  localparam logic [11:0] A_GEIP    = 12'hE12;

  // Status fields software may change
  localparam logic [63:0] STATUS_KEEP = 64'h0000_0000_0073_F3E0;
  // Guest width field, fixed by hardware
  localparam logic [63:0] STATUS_GW   = 64'h0000_0003_0000_0000;
  // Delegation causes that can never be delegated here
  localparam logic [63:0] DELEG_HOLES = 64'h0000_0000_00F0_0E00;
  localparam logic [63:0] CTREN_KEEP  = 64'h0000_0000_0000_0007;

  function automatic logic [63:0] gw_reset(input int xlen);
    return (xlen == 64) ? 64'h0000_0002_0000_0000 : 64'h0;
  endfunction

  // New status from old value and written word
  function automatic logic [63:0] legal_status(input logic [63:0] old_v,
                                               input logic [63:0] wr_v);
    return (wr_v & STATUS_KEEP) | (old_v & STATUS_GW);
  endfunction

  function automatic logic [63:0] legal_masked(input logic [63:0] wr_v,
                                               input logic [63:0] keep);
    return wr_v & keep;
  endfunction

  // Merge a write into one half (or the whole) of a 64-bit register
  function automatic logic [63:0] merge_half(input logic [63:0] old_v,
                                             input logic [63:0] wr_v,
                                             input bit        full,
                                             input bit        upper);
    logic [63:0] r;
    if (full)       r = wr_v;
    else if (upper) r = {wr_v[31:0], old_v[31:0]};
    else            r = {old_v[63:32], wr_v[31:0]};
    return r;
  endfunction

endpackage

// File: rtl/hyp_masked_reg.sv
module hyp_masked_reg #(
  parameter int              W     = 64,
  parameter logic [W-1:0]    WMASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  import hyp_ctrl_pkg::*;

  logic [W-1:0] nxt;

  always_comb begin
    nxt = W'(legal_masked(64'(wdata), 64'(WMASK)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= nxt;
  end
endmodule

// File: rtl/hyp_status_reg.sv
module hyp_status_reg #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] q,
  output logic [1:0]      gw
);
  import hyp_ctrl_pkg::*;

  localparam logic [XLEN-1:0] RST_V = XLEN'(gw_reset(XLEN));

  logic [XLEN-1:0] nxt;

  always_comb begin
    nxt = XLEN'(legal_status(64'(q), 64'(wdata)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST_V;
    else if (we) q <= nxt;
  end

  generate
    if (XLEN == 64) begin : g_gw
      assign gw = q[33:32];
    end else begin : g_nogw
      assign gw = 2'b00;
    end
  endgenerate
endmodule

// File: rtl/hyp_envcfg_reg.sv
module hyp_envcfg_reg #(
  parameter int XLEN          = 64,
  parameter bit FIOM_WRITABLE = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_lo,
  input  logic            we_hi,
  input  logic [XLEN-1:0] wdata,
  output logic [63:0]     cfg
);
  import hyp_ctrl_pkg::*;

  localparam logic [63:0] KEEP = FIOM_WRITABLE ? 64'h1 : 64'h0;
  localparam bit          FULL = (XLEN == 64);

  logic [63:0] wr64;
  logic [63:0] merged;
  logic        hi_ok;
  logic        do_wr;

  assign wr64  = 64'(wdata);
  assign hi_ok = we_hi & !FULL;
  assign do_wr = we_lo | hi_ok;

  always_comb begin
    merged = merge_half(cfg, wr64, FULL, hi_ok & !we_lo);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg <= '0;
    else if (do_wr) cfg <= legal_masked(merged, KEEP);
  end
endmodule

// File: rtl/hyp_read_mux.sv
module hyp_read_mux #(
  parameter int XLEN = 64
) (
  input  logic [11:0]     addr,
  input  logic [XLEN-1:0] status_v,
  input  logic [XLEN-1:0] deleg_v,
  input  logic [XLEN-1:0] ctren_v,
  input  logic [XLEN-1:0] geie_v,
  input  logic [63:0]     envcfg_v,
  input  logic [XLEN-1:0] tval_v,
  input  logic [XLEN-1:0] tinst_v,
  input  logic [XLEN-1:0] geip_v,
  output logic [XLEN-1:0] rdata
);
  import hyp_ctrl_pkg::*;

  localparam bit SPLIT = (XLEN == 32);

  logic [XLEN-1:0] env_hi;
  assign env_hi = SPLIT ? XLEN'(envcfg_v[63:32]) : '0;

  always_comb begin
    unique case (addr)
      A_STATUS:  rdata = status_v;
      A_EDELEG:  rdata = deleg_v;
      A_CTREN:   rdata = ctren_v;
      A_GEIE:    rdata = geie_v;
      A_ENVCFG:  rdata = envcfg_v[XLEN-1:0];
      A_ENVCFGH: rdata = env_hi;
      A_TVAL:    rdata = tval_v;
      A_TINST:   rdata = tinst_v;
      A_GEIP:    rdata = geip_v;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/hyp_ctrl_regs.sv
module hyp_ctrl_regs #(
  parameter int XLEN          = 64,
  parameter bit FIOM_WRITABLE = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [11:0]     csr_addr,
  input  logic            csr_we,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  input  logic [XLEN-1:0] guest_pend_i,
  output logic [5:0]      vgein_o,
  output logic            spv_o,
  output logic            spvp_o,
  output logic            vtsr_o,
  output logic            vtw_o,
  output logic            vtvm_o,
  output logic            hu_o,
  output logic            gva_o,
  output logic            vsbe_o,
  output logic [XLEN-1:0] exc_deleg_o,
  output logic [2:0]      ctr_en_o,
  output logic            fiom_o
);
  import hyp_ctrl_pkg::*;

  localparam logic [XLEN-1:0] DELEG_WMASK = ~XLEN'(DELEG_HOLES);
  localparam logic [XLEN-1:0] GEIE_WMASK  = ~XLEN'(1);
  localparam logic [XLEN-1:0] CTREN_WMASK = XLEN'(CTREN_KEEP);
  localparam logic [XLEN-1:0] FULL_WMASK  = '1;

  // Decoded write strobes, named for the checker
  logic wr_status, wr_deleg, wr_ctren, wr_geie;
  logic wr_env_lo, wr_env_hi, wr_tval, wr_tinst;

  assign wr_status = csr_we && (csr_addr == A_STATUS);
  assign wr_deleg  = csr_we && (csr_addr == A_EDELEG);
  assign wr_ctren  = csr_we && (csr_addr == A_CTREN);
  assign wr_geie   = csr_we && (csr_addr == A_GEIE);
  assign wr_env_lo = csr_we && (csr_addr == A_ENVCFG);
  assign wr_env_hi = csr_we && (csr_addr == A_ENVCFGH) && (XLEN == 32);
  assign wr_tval   = csr_we && (csr_addr == A_TVAL);
  assign wr_tinst  = csr_we && (csr_addr == A_TINST);

  logic [XLEN-1:0] status_q, deleg_q, ctren_q, geie_q, tval_q, tinst_q;
  logic [63:0]     envcfg_q;
  logic [1:0]      gw_field;

  hyp_status_reg #(.XLEN(XLEN)) u_status (
    .clk(clk), .rst_n(rst_n), .we(wr_status), .wdata(csr_wdata),
    .q(status_q), .gw(gw_field)
  );

  hyp_masked_reg #(.W(XLEN), .WMASK(DELEG_WMASK)) u_deleg (
    .clk(clk), .rst_n(rst_n), .we(wr_deleg), .wdata(csr_wdata), .q(deleg_q)
  );

  hyp_masked_reg #(.W(XLEN), .WMASK(CTREN_WMASK)) u_ctren (
    .clk(clk), .rst_n(rst_n), .we(wr_ctren), .wdata(csr_wdata), .q(ctren_q)
  );

  hyp_masked_reg #(.W(XLEN), .WMASK(GEIE_WMASK)) u_geie (
    .clk(clk), .rst_n(rst_n), .we(wr_geie), .wdata(csr_wdata), .q(geie_q)
  );

  hyp_masked_reg #(.W(XLEN), .WMASK(FULL_WMASK)) u_tval (
    .clk(clk), .rst_n(rst_n), .we(wr_tval), .wdata(csr_wdata), .q(tval_q)
  );

  hyp_masked_reg #(.W(XLEN), .WMASK(FULL_WMASK)) u_tinst (
    .clk(clk), .rst_n(rst_n), .we(wr_tinst), .wdata(csr_wdata), .q(tinst_q)
  );

  hyp_envcfg_reg #(.XLEN(XLEN), .FIOM_WRITABLE(FIOM_WRITABLE)) u_envcfg (
    .clk(clk), .rst_n(rst_n), .we_lo(wr_env_lo), .we_hi(wr_env_hi),
    .wdata(csr_wdata), .cfg(envcfg_q)
  );

  hyp_read_mux #(.XLEN(XLEN)) u_rmux (
    .addr(csr_addr), .status_v(status_q), .deleg_v(deleg_q),
    .ctren_v(ctren_q), .geie_v(geie_q), .envcfg_v(envcfg_q),
    .tval_v(tval_q), .tinst_v(tinst_q), .geip_v(guest_pend_i),
    .rdata(csr_rdata)
  );

  // Field exports
  assign vgein_o     = status_q[17:12];
  assign vtsr_o      = status_q[22];
  assign vtw_o       = status_q[21];
  assign vtvm_o      = status_q[20];
  assign hu_o        = status_q[9];
  assign spvp_o      = status_q[8];
  assign spv_o       = status_q[7];
  assign gva_o       = status_q[6];
  assign vsbe_o      = status_q[5];
  assign exc_deleg_o = deleg_q;
  assign ctr_en_o    = ctren_q[2:0];
  assign fiom_o      = envcfg_q[0];
endmodule

// File: rtl/hyp_ctrl_regs_chk.sv
module hyp_ctrl_regs_chk #(
  parameter int XLEN          = 64,
  parameter bit FIOM_WRITABLE = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [11:0]     csr_addr,
  input logic            csr_we,
  input logic [XLEN-1:0] csr_wdata,
  input logic [XLEN-1:0] csr_rdata,
  input logic [XLEN-1:0] guest_pend_i,
  input logic [5:0]      vgein_o,
  input logic [XLEN-1:0] exc_deleg_o,
  input logic            fiom_o,
  input logic [1:0]      gw_field
);
  localparam logic [63:0] RD_OK64 = (XLEN == 64) ? 64'h0000_0003_0073_F3E0
                                                 : 64'h0000_0000_0073_F3E0;
  localparam logic [XLEN-1:0] RD_OK  = XLEN'(RD_OK64);
  localparam logic [XLEN-1:0] HOLES  = XLEN'(64'h0000_0000_00F0_0E00);
  localparam logic [XLEN-1:0] CT_OK  = XLEN'(7);

  // R2 / R4: status read never shows bits outside the allowed fields
  a_r2_status_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == 12'h600) |-> ((csr_rdata & ~RD_OK) == '0));

  // R3: guest width field never moves
  a_r3_gw_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(gw_field));

  // R5: non-delegable causes stay clear
  a_r5_deleg_holes: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |-> ((exc_deleg_o & HOLES) == '0));

  // R6: enable bit 0 reads zero
  a_r6_geie_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == 12'h607) |-> !csr_rdata[0]);

  // R7: counter enable upper bits read zero
  a_r7_ctren_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == 12'h606) |-> ((csr_rdata & ~CT_OK) == '0));

  // R8: locked fence bit stays clear
  a_r8_fiom_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !FIOM_WRITABLE |-> !fiom_o);

  // R11: pending view follows the input lines
  a_r11_pend_view: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == 12'hE12) |-> (csr_rdata == guest_pend_i));

  // R12: exported guest interrupt number follows a status write
  a_r12_vgein_export: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr == 12'h600) |=> (vgein_o == $past(csr_wdata[17:12])));
endmodule

bind hyp_ctrl_regs hyp_ctrl_regs_chk #(.XLEN(XLEN), .FIOM_WRITABLE(FIOM_WRITABLE)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_we(csr_we),
  .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .guest_pend_i(guest_pend_i),
  .vgein_o(vgein_o), .exc_deleg_o(exc_deleg_o), .fiom_o(fiom_o),
  .gw_field(gw_field)
);

// File: tb/hyp_ctrl_regs_bench.sv
`timescale 1ns/1ps
module hyp_ctrl_regs_bench;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic        rst_n;
  logic [11:0] addr;
  logic        we;
  logic [63:0] wd;
  logic [63:0] pend;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit rphase = 0;

  // Instance 0: 64-bit, fence bit locked
  logic [63:0] rd0, dl0;
  logic [5:0]  vg0;
  logic [2:0]  ct0;
  logic        fi0, a0, b0, c0, d0, e0, f0, g0, h0;

  hyp_ctrl_regs #(.XLEN(64), .FIOM_WRITABLE(1'b0)) u_hyp_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .csr_addr(addr), .csr_we(we), .csr_wdata(wd),
    .csr_rdata(rd0), .guest_pend_i(pend), .vgein_o(vg0),
    .spv_o(f0), .spvp_o(e0), .vtsr_o(a0), .vtw_o(b0), .vtvm_o(c0), .hu_o(d0),
    .gva_o(g0), .vsbe_o(h0), .exc_deleg_o(dl0), .ctr_en_o(ct0), .fiom_o(fi0)
  );

  // Instance 1: 32-bit, fence bit writable
  logic [31:0] rd1, dl1;
  logic [5:0]  vg1;
  logic [2:0]  ct1;
  logic        fi1, a1, b1, c1, d1, e1, f1, g1, h1;

  hyp_ctrl_regs #(.XLEN(32), .FIOM_WRITABLE(1'b1)) u_hyp_ctrl_regs_rv32 (
    .clk(clk), .rst_n(rst_n), .csr_addr(addr), .csr_we(we), .csr_wdata(wd[31:0]),
    .csr_rdata(rd1), .guest_pend_i(pend[31:0]), .vgein_o(vg1),
    .spv_o(f1), .spvp_o(e1), .vtsr_o(a1), .vtw_o(b1), .vtvm_o(c1), .hu_o(d1),
    .gva_o(g1), .vsbe_o(h1), .exc_deleg_o(dl1), .ctr_en_o(ct1), .fiom_o(fi1)
  );

  // Reference model state, index 0 = 64-bit instance, 1 = 32-bit instance
  logic [63:0] m_st[2], m_dl[2], m_ct[2], m_ge[2], m_ev[2], m_tv[2], m_ti[2];
  int keep_pos[14] = '{5, 6, 7, 8, 9, 12, 13, 14, 15, 16, 17, 20, 21, 22};
  int hole_pos[7]  = '{9, 10, 11, 20, 21, 22, 23};

  function automatic logic [63:0] xm(input int i);
    return (i == 1) ? 64'h0000_0000_FFFF_FFFF : {64{1'b1}};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_st[i] = (i == 0) ? (64'd2 << 32) : 64'd0;   // R1 guest width on 64-bit
      m_dl[i] = 0; m_ct[i] = 0; m_ge[i] = 0; m_ev[i] = 0; m_tv[i] = 0; m_ti[i] = 0;
    end
  endtask

  task automatic model_write(input int i, input logic [11:0] a, input logic [63:0] d);
    logic [63:0] w, v;
    w = d & xm(i);
    case (a)
      12'h600: begin
        v = m_st[i] & (64'd3 << 32);             // R3 width field retained
        foreach (keep_pos[k]) v[keep_pos[k]] = w[keep_pos[k]];
        m_st[i] = v;
      end
      12'h602: begin
        v = w;
        foreach (hole_pos[k]) v[hole_pos[k]] = 1'b0;
        m_dl[i] = v;
      end
      12'h606: m_ct[i] = {61'd0, w[2:0]};
      12'h607: begin v = w; v[0] = 1'b0; m_ge[i] = v; end
      12'h60A: if (i == 1) m_ev[i][0] = w[0];      // only instance 1 may set it
      12'h643: m_tv[i] = w;
      12'h64A: m_ti[i] = w;
      default: ;                                    // 0x61A: no writable upper bits
    endcase
  endtask

  function automatic logic [63:0] exp_read(input int i, input logic [11:0] a);
    case (a)
      12'h600: return m_st[i];
      12'h602: return m_dl[i];
      12'h606: return m_ct[i];
      12'h607: return m_ge[i];
      12'h60A: return m_ev[i] & xm(i);
      12'h61A: return (i == 1) ? {32'd0, m_ev[i][63:32]} : 64'd0;
      12'h643: return m_tv[i];
      12'h64A: return m_ti[i];
      12'hE12: return pend & xm(i);
      default: return 64'd0;
    endcase
  endfunction

  function automatic string tag_of(input int i, input logic [11:0] a);
    if (rphase) return "R1";
    if (we)     return "R13";
    case (a)
      12'h600: return (i == 1) ? "R4" : "R2";
      12'h602: return "R5";
      12'h606: return "R7";
      12'h607: return "R6";
      12'h60A: return "R8";
      12'h61A: return "R9";
      12'h643, 12'h64A: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string tag, input int i, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s inst%0d addr %h: actual %h expected %h", tag, i, addr, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [63:0] s;
    chk(tag_of(0, addr), 0, rd0, exp_read(0, addr));
    chk(tag_of(1, addr), 1, {32'd0, rd1}, exp_read(1, addr));
    s = m_st[0];
    chk("R12", 0, {58'd0, vg0}, {58'd0, s[17:12]});
    chk("R12", 0, {56'd0, a0, b0, c0, d0, e0, f0, g0, h0},
        {56'd0, s[22], s[21], s[20], s[9], s[8], s[7], s[6], s[5]});
    s = m_st[1];
    chk("R12", 1, {58'd0, vg1}, {58'd0, s[17:12]});
    chk("R12", 1, {56'd0, a1, b1, c1, d1, e1, f1, g1, h1},
        {56'd0, s[22], s[21], s[20], s[9], s[8], s[7], s[6], s[5]});
    chk("R5", 0, dl0, m_dl[0]);
    chk("R5", 1, {32'd0, dl1}, m_dl[1]);
    chk("R7", 0, {61'd0, ct0}, m_ct[0]);
    chk("R7", 1, {61'd0, ct1}, m_ct[1]);
    chk("R8", 0, {63'd0, fi0}, {63'd0, m_ev[0][0]});
    chk("R8", 1, {63'd0, fi1}, {63'd0, m_ev[1][0]});
  endtask

  task automatic step(input logic [11:0] a, input bit w, input logic [63:0] d);
    @(negedge clk);
    addr = a; we = w; wd = d;
    #0.5;
    compare_all();
    @(posedge clk);
    if (w && rst_n) begin
      model_write(0, a, d);
      model_write(1, a, d);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  logic [11:0] alist[10] = '{12'h600, 12'h602, 12'h606, 12'h607, 12'h60A,
                            12'h61A, 12'h643, 12'h64A, 12'hE12, 12'h123};

  initial begin
    logic [63:0] lf;
    rst_n = 1'b0; addr = 12'h600; we = 1'b0; wd = '0; pend = 64'h0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values at every address
    rphase = 1;
    foreach (alist[k]) step(alist[k], 1'b0, 64'd0);
    rphase = 0;

    // R2 R3 R4 R12: status legalization
    step(12'h600, 1'b1, {64{1'b1}});
    step(12'h600, 1'b0, 64'd0);
    checks++;
    if (rd0[33:32] !== 2'b10) begin
      fails++;
      $display("FAIL R3 width field: actual %b expected 10", rd0[33:32]);
    end
    step(12'h600, 1'b1, 64'hFFFF_FFFC_FF8C_0C1F);
    step(12'h600, 1'b0, 64'd0);
    step(12'h600, 1'b1, 64'h0000_0000_0041_A0A0);
    step(12'h600, 1'b0, 64'd0);

    // R5 delegation holes
    step(12'h602, 1'b1, {64{1'b1}});
    step(12'h602, 1'b0, 64'd0);
    step(12'h602, 1'b1, 64'h8000_0001_00A5_0F5A);
    step(12'h602, 1'b0, 64'd0);

    // R7 R6 counter and guest enables
    step(12'h606, 1'b1, {64{1'b1}});
    step(12'h606, 1'b0, 64'd0);
    step(12'h607, 1'b1, {64{1'b1}});
    step(12'h607, 1'b0, 64'd0);

    // R8 R9 configuration halves
    step(12'h60A, 1'b1, {64{1'b1}});
    step(12'h60A, 1'b0, 64'd0);
    step(12'h61A, 1'b1, {64{1'b1}});
    step(12'h60A, 1'b0, 64'd0);
    step(12'h61A, 1'b0, 64'd0);
    step(12'h60A, 1'b1, 64'd0);
    step(12'h60A, 1'b0, 64'd0);

    // R10 trap storage
    step(12'h643, 1'b1, 64'hDEAD_BEEF_0123_4567);
    step(12'h64A, 1'b1, 64'h0F0F_F0F0_55AA_AA55);
    step(12'h643, 1'b0, 64'd0);
    step(12'h64A, 1'b0, 64'd0);

    // R11 pending view and unmapped addresses
    pend = 64'h8000_0000_0000_0006;
    step(12'hE12, 1'b1, {64{1'b1}});
    step(12'hE12, 1'b0, 64'd0);
    pend = 64'h0000_0003_8000_0010;
    step(12'hE12, 1'b0, 64'd0);
    step(12'h123, 1'b1, {64{1'b1}});
    step(12'h123, 1'b0, 64'd0);

    // Mixed traffic, every register, all rules
    lf = 64'hACE1_1234_5678_9ABC;
    for (int n = 0; n < 400; n++) begin
      lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
      if (n % 50 == 0) pend = {lf[31:0], lf[63:32]};
      step(alist[lf[11:8] % 10], lf[3], {lf[40:0], lf[63:41]});
    end

    @(negedge clk);
    we = 1'b0;
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule